// File: doc/BRIEF.md
# Reset Release Delay Generator

This block turns two supply-level flags and a manual reset pin into an active-low system reset. The reset is released only after a programmed delay. A charge counter stands in for the timing capacitor. The counter climbs by a small step on every clock while nothing is wrong. It falls by a large step on every clock while a supply fault or a manual reset is present. The reset is held asserted until the counter sits at full scale.

A fault that ends before the counter reaches zero leaves charge behind, so the next release comes early in proportion to the charge that is left. This matches a capacitor that was only partly discharged. Any fault on the supply-low flag or on the raw manual reset pin takes the reset low in the same cycle, through a combinational path. A second output tells whether the most recent assertion came from the manual pin or from the supply.

Top module: `rst_release_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `sys_rst_n_o` is 0 and `cause_manual_o` is 0. The charge counter starts at zero, so the first release takes the full delay.
- R2: The supply-above flag is raised just after clock edge c, with no fault present. `sys_rst_n_o` is still 0 after edge c+FULL_SCALE and is 1 after edge c+FULL_SCALE+1 (UP_STEP=1).
- R3: A high `supply_low_i` drives `sys_rst_n_o` to 0 in the same cycle, with no clock edge needed.
- R4: The counter drops by DN_STEP, never below zero, on each edge where a fault is seen. It rises by UP_STEP, never above FULL_SCALE, on each edge with no fault. A fault is seen when `supply_low_i` is high, the supply-good state is low, or the synchronized manual reset is low.
- R5: A supply fault sees L edges with `supply_low_i` high, and then `supply_ok_i` is raised. This drains L+1 steps, because the restore edge still finds the supply-good state low. Release follows (FULL_SCALE − remaining charge) edges later, which is shorter than the full delay when charge remains.
- R6: The supply-good state is set by `supply_ok_i` and cleared by `supply_low_i`, and `supply_low_i` wins when both are high. With both flags low the state is held, so a released reset stays released.
- R7: A low `mr_n_i` drives `sys_rst_n_o` to 0 in the same cycle, whatever the supply flags are.
- R8: `mr_n_i` passes through SYNC_STAGES=2 flops before it reaches the counter. Suppose it goes low just after edge c and stays low for M edges. The counter then drains on edges c+3 through c+M+2. It charges from edge c+M+3 onward, and release comes at edge c+M+2+(FULL_SCALE − remaining charge).
- R9: `cause_manual_o` is set to 1 on any edge where the synchronized manual reset is low. It is cleared to 0 on an edge where a supply fault is seen and the manual reset is high. Manual reset wins when both are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| supply_ok_i | input | 1 | Supply is above the release level (synchronous) |
| supply_low_i | input | 1 | Supply is at or below the detect level (synchronous) |
| mr_n_i | input | 1 | Manual reset pin, active low, asynchronous |
| sys_rst_n_o | output | 1 | System reset, active low |
| cause_manual_o | output | 1 | 1: last assertion came from the manual pin; 0: from the supply |

## Verification
A wrong counter value is hidden while reset is held. It shows up only as a release edge that comes early or late, sometimes thousands of cycles after the fault that caused it. For that reason each release is checked on the exact cycle and on the cycle before, after partial drains of known depth from both the supply path and the manual path. A wrong supply-good state or a wrong synchronizer depth shows up within a few cycles as a missed release or as a release that is shifted by one or two edges.

// File: rtl/rrd_pkg.sv
// Shared types for the reset release delay generator.
package rrd_pkg;
    typedef enum logic {
        CAUSE_SUPPLY = 1'b0,
        CAUSE_MANUAL = 1'b1
    } rrd_cause_e;
endpackage

// File: rtl/rrd_sync.sv
// rrd_sync: multi-flop synchronizer for an asynchronous active-low level.
// Assumes: the input is a slow level. The flops reset to the inactive (high) value.
module rrd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n_i,
    output logic sync_n_o
);
    logic [STAGES-1:0] chain_q;

    // Stage 0 samples the pin; each later stage samples the one before it.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b1;
        else        chain_q[0] <= async_n_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Shift one stage along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= 1'b1;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/rrd_supply_track.sv
// rrd_supply_track: keeps the supply-good state from the upper and lower level flags.
// Assumes: both flags are synchronous and already carry hysteresis. The low flag wins.
module rrd_supply_track (
    input  logic clk,
    input  logic rst_n,
    input  logic above_i,
    input  logic below_i,
    output logic good_o
);
    logic good_q;

    // Set on the upper flag, clear on the lower flag, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       good_q <= 1'b0;
        else if (below_i) good_q <= 1'b0;
        else if (above_i) good_q <= 1'b1;
    end

    assign good_o = good_q;

    a_r6_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        below_i |=> !good_o);
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!below_i && !above_i) |=> $stable(good_o));
endmodule

// File: rtl/rrd_charge.sv
// rrd_charge: saturating charge counter that models the delay capacitor.
// Assumes: UP_STEP and DN_STEP are both between 1 and FULL_SCALE.
module rrd_charge #(
    parameter int FULL_SCALE = 10000,
    parameter int UP_STEP    = 1,
    parameter int DN_STEP    = 2500,
    localparam int CW        = $clog2(FULL_SCALE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drain_i,
    output logic [CW-1:0] level_o,
    output logic          full_o
);
    localparam logic [CW-1:0] FULL_C = CW'(FULL_SCALE);
    localparam logic [CW-1:0] UP_C   = CW'(UP_STEP);
    localparam logic [CW-1:0] DN_C   = CW'(DN_STEP);

    logic [CW-1:0] lvl_q;
    logic [CW-1:0] lvl_d;

    // Next level: drop with a floor at zero, or climb with a ceiling at full scale.
    always_comb begin
        lvl_d = lvl_q;
        if (drain_i) begin
            lvl_d = (lvl_q > DN_C) ? (lvl_q - DN_C) : '0;
        end else if (lvl_q < FULL_C) begin
            lvl_d = ((FULL_C - lvl_q) > UP_C) ? (lvl_q + UP_C) : FULL_C;
        end
    end

    // Level register, empty after power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign level_o = lvl_q;
    assign full_o  = (lvl_q == FULL_C);

    a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= FULL_C);
    a_r4_drain_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_i && lvl_q != '0) |=> (lvl_q < $past(lvl_q)));
    a_r4_charge_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_i && lvl_q < FULL_C) |=> (lvl_q > $past(lvl_q)));
endmodule

// File: rtl/rst_release_gen.sv
// rst_release_gen: active-low system reset with a charge-based release delay.
// Assumes: supply flags are synchronous to clk, and mr_n_i may be asynchronous.
// Assertion of the reset is combinational on supply_low_i and mr_n_i.
// Release waits until the charge counter is full.
module rst_release_gen
    import rrd_pkg::*;
#(
    parameter int FULL_SCALE  = 10000,
    parameter int UP_STEP     = 1,
    parameter int DN_STEP     = 2500,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(FULL_SCALE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic supply_low_i,
    input  logic mr_n_i,
    output logic sys_rst_n_o,
    output logic cause_manual_o
);
    logic          mr_sync_n;
    logic          sup_good;
    logic          sup_fault;
    logic          fault;
    logic          full_w;
    logic [CW-1:0] level_w;
    rrd_cause_e    cause_q;

    rrd_sync #(.STAGES(SYNC_STAGES)) u_mr_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_n_i (mr_n_i),
        .sync_n_o  (mr_sync_n)
    );

    rrd_supply_track u_supply (
        .clk     (clk),
        .rst_n   (rst_n),
        .above_i (supply_ok_i),
        .below_i (supply_low_i),
        .good_o  (sup_good)
    );

    assign sup_fault = supply_low_i | ~sup_good;
    assign fault     = sup_fault | ~mr_sync_n;

    rrd_charge #(
        .FULL_SCALE (FULL_SCALE),
        .UP_STEP    (UP_STEP),
        .DN_STEP    (DN_STEP)
    ) u_charge (
        .clk     (clk),
        .rst_n   (rst_n),
        .drain_i (fault),
        .level_o (level_w),
        .full_o  (full_w)
    );

    // Remember which source asserted reset last; the manual pin has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)          cause_q <= CAUSE_SUPPLY;
        else if (!mr_sync_n) cause_q <= CAUSE_MANUAL;
        else if (sup_fault)  cause_q <= CAUSE_SUPPLY;
    end

    assign cause_manual_o = (cause_q == CAUSE_MANUAL);
    assign sys_rst_n_o    = full_w & ~fault & mr_n_i;

    a_r2_release_after_charge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n_o) |-> (32'($past(level_w)) + UP_STEP >= FULL_SCALE));
    a_r9_manual_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_sync_n |=> cause_manual_o);
endmodule

// File: tb/tb_rst_release_gen.sv
// Scoreboard bench: driver tasks queue expected outputs per cycle; a monitor compares them.
module tb_rst_release_gen;
    localparam int FULL = 10000;
    localparam int DN   = 2500;
    localparam int WDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic supply_low = 1'b0;
    logic mr_n = 1'b1;
    logic sys_rst_n;
    logic cause_manual;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        int    at;
        bit    rst;
        bit    chk_cause;
        bit    cause;
        string tag;
    } item_t;

    item_t q[$];

    rst_release_gen dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok_i    (supply_ok),
        .supply_low_i   (supply_low),
        .mr_n_i         (mr_n),
        .sys_rst_n_o    (sys_rst_n),
        .cause_manual_o (cause_manual)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int at, input bit r, input bit cc, input bit ca, input string tag);
        item_t it;
        it.at = at; it.rst = r; it.chk_cause = cc; it.cause = ca; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops each queued item on its cycle and compares it with the ports.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].at <= cyc) begin
                total++;
                if (q[0].at != cyc) begin
                    bad++;
                    $display("FAIL %s: sample missed, cycle %0d expected %0d", q[0].tag, cyc, q[0].at);
                end else if (sys_rst_n !== q[0].rst) begin
                    bad++;
                    $display("FAIL %s: sys_rst_n=%0b expected %0b at cycle %0d", q[0].tag, sys_rst_n, q[0].rst, cyc);
                end else if (q[0].chk_cause && cause_manual !== q[0].cause) begin
                    bad++;
                    $display("FAIL %s: cause_manual=%0b expected %0b at cycle %0d", q[0].tag, cause_manual, q[0].cause, cyc);
                end
                void'(q.pop_front());
            end
        end
    end

    // Supply fault of len edges from full charge, then restore (R5, R4, R9).
    task automatic supply_fault(input int len, input string tag);
        int c, rem, rel;
        @(negedge clk);
        c = cyc;
        supply_low = 1'b1; supply_ok = 1'b0;
        push(c, 1'b0, 1'b0, 1'b0, {tag, "_R3_immediate"});
        wait_cyc(len);
        supply_low = 1'b0; supply_ok = 1'b1;
        rem = FULL - (len + 1) * DN;
        if (rem < 0) rem = 0;
        rel = c + len + 1 + (FULL - rem);
        push(rel - 1, 1'b0, 1'b1, 1'b0, {tag, "_R5_before"});
        push(rel, 1'b1, 1'b1, 1'b0, {tag, "_R5_R9_release"});
        while (cyc < rel + 2) @(negedge clk);
    endtask

    // Manual reset low for m edges, then high (R7, R8, R9).
    task automatic manual_pulse(input int m, input string tag);
        int c, rem, rel;
        @(negedge clk);
        c = cyc;
        mr_n = 1'b0;
        push(c, 1'b0, 1'b0, 1'b0, {tag, "_R7_immediate"});
        wait_cyc(m);
        mr_n = 1'b1;
        rem = FULL - m * DN;
        if (rem < 0) rem = 0;
        rel = c + m + 2 + (FULL - rem);
        push(rel - 1, 1'b0, 1'b1, 1'b1, {tag, "_R8_before"});
        push(rel, 1'b1, 1'b1, 1'b1, {tag, "_R8_R9_release"});
        while (cyc < rel + 2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        wait (cyc >= WDOG);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: cycle=%0d expected < %0d", cyc, WDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c;
        wait_cyc(3);
        push(cyc, 1'b0, 1'b1, 1'b0, "R1_in_reset");
        @(negedge clk);
        rst_n = 1'b1;
        push(cyc, 1'b0, 1'b1, 1'b0, "R1_after_reset");
        wait_cyc(2);

        // R1/R2: first release from an empty counter takes the full delay.
        @(negedge clk);
        c = cyc;
        supply_ok = 1'b1;
        push(c + FULL, 1'b0, 1'b1, 1'b0, "R2_before_release");
        push(c + FULL + 1, 1'b1, 1'b1, 1'b0, "R2_release");
        while (cyc < c + FULL + 3) @(negedge clk);

        // R6: both flags low holds the supply-good state, so reset stays released.
        @(negedge clk);
        c = cyc;
        supply_ok = 1'b0;
        push(c + 1, 1'b1, 1'b0, 1'b0, "R6_hold_1");
        push(c + 4, 1'b1, 1'b0, 1'b0, "R6_hold_4");
        wait_cyc(6);
        supply_ok = 1'b1;
        wait_cyc(2);

        // R7/R8/R9: short manual pulse drains once, so release comes early.
        manual_pulse(1, "mr_short");
        // R4/R5/R9: one-edge supply dip drains two steps; cause returns to supply.
        supply_fault(1, "sup_short");
        // R8/R4: long manual pulse empties the counter, so a full delay follows.
        manual_pulse(6, "mr_long");
        // R4: long supply fault floors the counter at zero.
        supply_fault(5, "sup_long");

        // R6: low flag wins over the upper flag when both are high.
        @(negedge clk);
        c = cyc;
        supply_low = 1'b1; supply_ok = 1'b1;
        wait_cyc(1);
        supply_low = 1'b0;
        push(c + 2, 1'b0, 1'b0, 1'b0, "R6_low_wins");
        wait_cyc(4);

        if (q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: pending=%0d expected 0", q.size());
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule